// File: doc/BRIEF.md
# PCI Bridge Read Parity Reporter

This block checks data parity on read data that crosses a two-sided PCI bridge, and reports each failure on the bus that carried it. The bus where the bridge acts as target for a read is watched on every data phase. The 32 address/data bits and 4 command/byte-enable bits of a phase are held for one clock. They are then checked against the parity bit that arrives on the next clock. A failure drives the active-low parity-error output of that bus for one cycle, two clocks after the data phase, when that bus has its response enable set. The failure also sets sticky status and interrupt status bits, each under its own condition.

Every word seen in a data phase goes into a small delayed-read-completion buffer, unchanged, with the parity bit that arrived for it. This includes words with bad parity. The buffer is drained by the initiating bus, so the initiator sees the bad parity itself and handles its own reporting. Invalidating the buffer throws away any words not yet read, with no status effect. The primary side (index 0) fills the upstream buffer, which is delivered to the secondary bus. The secondary side (index 1) fills the downstream buffer, which is delivered to the primary bus.

Top module: `prp_top`

## Requirements
- R1: A data phase on a side is a clock where its tgt_rd, irdy and trdy inputs are all 1. If the parity bit sampled on the next clock does not make the count of ones over {ad, cbe, par} even, that side's perr_n goes 0 for one cycle, two clocks after the data phase. Otherwise it stays 1.
- R2: perr_n of a side is driven 0 only when that side's resp_en is 1 on the clock the report is made.
- R3: Status bit 0 (data parity detected) of the failing side is set only when its resp_en is 1.
- R4: Status bit 1 (detected parity error) of the failing side is set on every failure, whatever the enables.
- R5: Status bit 2 (master parity interrupt) is set on a failure only when that side's mpe_mask is 0.
- R6: Status bit 3 (detected parity interrupt) is set on a failure only when that side's dpe_mask is 0.
- R7: Status bits are sticky and cleared by a 1 in the matching clr bit. When a clear and a set of the same bit fall in one clock, the bit ends up set.
- R8: Each data-phase word is written into the buffer one clock after its data phase, as {ad, cbe, par}, with the parity unaltered. Words leave in arrival order: the head shows on *_ad/*_cbe/*_par while *_valid is 1, and *_pop removes it.
- R9: A 1 on *_flush empties that buffer, including any word arriving in the same clock. No status bit and no perr_n changes as a result.
- R10: A failure on the primary side affects only p_perr_n, p_status and the upstream buffer. A failure on the secondary side affects only s_perr_n, s_status and the downstream buffer.
- R11: Failures on consecutive data phases give perr_n at 0 on consecutive cycles.
- R12: A buffer holds DRC_DEPTH words. A word arriving while the buffer is full is not stored, and a pop of an empty buffer does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_ad | input | 32 | Primary address/data |
| p_cbe | input | 4 | Primary command/byte enables |
| p_par | input | 1 | Primary parity (one clock after its word) |
| p_irdy | input | 1 | Primary initiator ready, active high |
| p_trdy | input | 1 | Primary target ready, active high |
| p_tgt_rd | input | 1 | Primary is target of a crossing read |
| p_resp_en | input | 1 | Primary parity error response enable |
| p_mpe_mask | input | 1 | Primary master parity interrupt mask |
| p_dpe_mask | input | 1 | Primary detected parity interrupt mask |
| p_clr | input | 4 | Primary status write-one-to-clear |
| p_status | output | 4 | Primary sticky status bits |
| p_perr_n | output | 1 | Primary parity error, active low |
| s_ad | input | 32 | Secondary address/data |
| s_cbe | input | 4 | Secondary command/byte enables |
| s_par | input | 1 | Secondary parity |
| s_irdy | input | 1 | Secondary initiator ready |
| s_trdy | input | 1 | Secondary target ready |
| s_tgt_rd | input | 1 | Secondary is target of a crossing read |
| s_resp_en | input | 1 | Secondary response enable |
| s_mpe_mask | input | 1 | Secondary master parity interrupt mask |
| s_dpe_mask | input | 1 | Secondary detected parity interrupt mask |
| s_clr | input | 4 | Secondary status write-one-to-clear |
| s_status | output | 4 | Secondary sticky status bits |
| s_perr_n | output | 1 | Secondary parity error, active low |
| up_pop | input | 1 | Remove head of upstream buffer |
| up_flush | input | 1 | Invalidate upstream buffer |
| up_valid | output | 1 | Upstream buffer not empty |
| up_ad | output | 32 | Upstream head data |
| up_cbe | output | 4 | Upstream head byte enables |
| up_par | output | 1 | Upstream head parity |
| dn_pop | input | 1 | Remove head of downstream buffer |
| dn_flush | input | 1 | Invalidate downstream buffer |
| dn_valid | output | 1 | Downstream buffer not empty |
| dn_ad | output | 32 | Downstream head data |
| dn_cbe | output | 4 | Downstream head byte enables |
| dn_par | output | 1 | Downstream head parity |

## Verification
Two pairs of actions can fall in one clock. A status clear can meet a new set of the same bit. A buffer flush can meet the write of a word that carries bad parity. Directed steps line each pair up on one edge. Random traffic on both sides also produces clears and flushes against ongoing failures. The outcome is judged against a bench model in which the set wins over the clear and the flush wins over the write. The model also gives the perr_n that the flushed word must not disturb.

// File: rtl/prp_pkg.sv
package prp_pkg;

    localparam int AD_W  = 32;
    localparam int CBE_W = 4;
    localparam int ST_W  = 4;

    // status bit positions
    localparam int ST_DPD  = 0;
    localparam int ST_DPE  = 1;
    localparam int ST_IMPE = 2;
    localparam int ST_IDPE = 3;

    typedef struct packed {
        logic [AD_W-1:0]  ad;
        logic [CBE_W-1:0] cbe;
    } prp_word_t;

    typedef struct packed {
        prp_word_t w;
        logic      par;
    } prp_entry_t;

    // even parity bit over a whole word
    function automatic logic even_par(input prp_word_t w);
        return ^w;
    endfunction

endpackage

// File: rtl/prp_phase_check.sv
module prp_phase_check
    import prp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  prp_word_t  word,
    input  logic       par,
    input  logic       dphase,
    output logic       cap_push,
    output prp_entry_t cap_entry,
    output logic       err_q
);
    logic      s1_v;
    prp_word_t s1_w;

    // stage 1: hold the data phase word until its parity arrives
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_w <= '0;
        end else begin
            s1_v <= dphase;
            s1_w <= word;
        end
    end

    // stage 2: compare and flag
    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= s1_v && (even_par(s1_w) != par);
    end

    assign cap_push      = s1_v;
    assign cap_entry.w   = s1_w;
    assign cap_entry.par = par;
endmodule

// File: rtl/prp_err_report.sv
module prp_err_report
    import prp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            err,
    input  logic            resp_en,
    input  logic            mpe_mask,
    input  logic            dpe_mask,
    input  logic [ST_W-1:0] clr,
    output logic [ST_W-1:0] status,
    output logic            perr_n
);
    logic [ST_W-1:0] set_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[ST_DPD]  = err && resp_en;
        set_vec[ST_DPE]  = err;
        set_vec[ST_IMPE] = err && !mpe_mask;
        set_vec[ST_IDPE] = err && !dpe_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            perr_n <= 1'b1;
        end else begin
            status <= (status & ~clr) | set_vec;
            perr_n <= !(err && resp_en);
        end
    end
endmodule

// File: rtl/prp_drc_buffer.sv
module prp_drc_buffer
    import prp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  prp_entry_t entry,
    input  logic       pop,
    input  logic       flush,
    output logic       valid,
    output prp_entry_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    prp_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign do_push = push && (count != FULLC);
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= entry;
    end

    assign valid = (count != '0);
    assign head  = mem[rd_ptr];
endmodule

// File: rtl/prp_top.sv
module prp_top
    import prp_pkg::*;
#(
    parameter int DRC_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AD_W-1:0]   p_ad,
    input  logic [CBE_W-1:0]  p_cbe,
    input  logic              p_par,
    input  logic              p_irdy,
    input  logic              p_trdy,
    input  logic              p_tgt_rd,
    input  logic              p_resp_en,
    input  logic              p_mpe_mask,
    input  logic              p_dpe_mask,
    input  logic [ST_W-1:0]   p_clr,
    output logic [ST_W-1:0]   p_status,
    output logic              p_perr_n,
    input  logic [AD_W-1:0]   s_ad,
    input  logic [CBE_W-1:0]  s_cbe,
    input  logic              s_par,
    input  logic              s_irdy,
    input  logic              s_trdy,
    input  logic              s_tgt_rd,
    input  logic              s_resp_en,
    input  logic              s_mpe_mask,
    input  logic              s_dpe_mask,
    input  logic [ST_W-1:0]   s_clr,
    output logic [ST_W-1:0]   s_status,
    output logic              s_perr_n,
    input  logic              up_pop,
    input  logic              up_flush,
    output logic              up_valid,
    output logic [AD_W-1:0]   up_ad,
    output logic [CBE_W-1:0]  up_cbe,
    output logic              up_par,
    input  logic              dn_pop,
    input  logic              dn_flush,
    output logic              dn_valid,
    output logic [AD_W-1:0]   dn_ad,
    output logic [CBE_W-1:0]  dn_cbe,
    output logic              dn_par
);
    localparam int NSIDE = 2; // 0 = primary, 1 = secondary

    prp_word_t       sd_word  [NSIDE];
    logic            sd_par   [NSIDE];
    logic            sd_dph   [NSIDE];
    logic            sd_resp  [NSIDE];
    logic            sd_mmask [NSIDE];
    logic            sd_dmask [NSIDE];
    logic [ST_W-1:0] sd_clr   [NSIDE];
    logic [ST_W-1:0] sd_stat  [NSIDE];
    logic            sd_perr  [NSIDE];
    logic            sd_err   [NSIDE];
    logic            sd_push  [NSIDE];
    prp_entry_t      sd_entry [NSIDE];
    logic            bf_pop   [NSIDE];
    logic            bf_flush [NSIDE];
    logic            bf_valid [NSIDE];
    prp_entry_t      bf_head  [NSIDE];

    assign sd_word[0]  = '{ad: p_ad, cbe: p_cbe};
    assign sd_par[0]   = p_par;
    assign sd_dph[0]   = p_tgt_rd && p_irdy && p_trdy;
    assign sd_resp[0]  = p_resp_en;
    assign sd_mmask[0] = p_mpe_mask;
    assign sd_dmask[0] = p_dpe_mask;
    assign sd_clr[0]   = p_clr;
    assign bf_pop[0]   = up_pop;
    assign bf_flush[0] = up_flush;

    assign sd_word[1]  = '{ad: s_ad, cbe: s_cbe};
    assign sd_par[1]   = s_par;
    assign sd_dph[1]   = s_tgt_rd && s_irdy && s_trdy;
    assign sd_resp[1]  = s_resp_en;
    assign sd_mmask[1] = s_mpe_mask;
    assign sd_dmask[1] = s_dpe_mask;
    assign sd_clr[1]   = s_clr;
    assign bf_pop[1]   = dn_pop;
    assign bf_flush[1] = dn_flush;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        prp_phase_check u_check (
            .clk       (clk),
            .rst       (rst),
            .word      (sd_word[g]),
            .par       (sd_par[g]),
            .dphase    (sd_dph[g]),
            .cap_push  (sd_push[g]),
            .cap_entry (sd_entry[g]),
            .err_q     (sd_err[g])
        );

        prp_err_report u_report (
            .clk      (clk),
            .rst      (rst),
            .err      (sd_err[g]),
            .resp_en  (sd_resp[g]),
            .mpe_mask (sd_mmask[g]),
            .dpe_mask (sd_dmask[g]),
            .clr      (sd_clr[g]),
            .status   (sd_stat[g]),
            .perr_n   (sd_perr[g])
        );

        prp_drc_buffer #(.DEPTH(DRC_DEPTH)) u_buf (
            .clk   (clk),
            .rst   (rst),
            .push  (sd_push[g]),
            .entry (sd_entry[g]),
            .pop   (bf_pop[g]),
            .flush (bf_flush[g]),
            .valid (bf_valid[g]),
            .head  (bf_head[g])
        );
    end

    assign p_status = sd_stat[0];
    assign p_perr_n = sd_perr[0];
    assign s_status = sd_stat[1];
    assign s_perr_n = sd_perr[1];

    assign up_valid = bf_valid[0];
    assign up_ad    = bf_head[0].w.ad;
    assign up_cbe   = bf_head[0].w.cbe;
    assign up_par   = bf_head[0].par;
    assign dn_valid = bf_valid[1];
    assign dn_ad    = bf_head[1].w.ad;
    assign dn_cbe   = bf_head[1].w.cbe;
    assign dn_par   = bf_head[1].par;
endmodule

// File: rtl/prp_checker.sv
module prp_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] p_ad,
    input logic [3:0]  p_cbe,
    input logic        p_par,
    input logic        p_irdy,
    input logic        p_trdy,
    input logic        p_tgt_rd,
    input logic        p_resp_en,
    input logic        p_mpe_mask,
    input logic [3:0]  p_clr,
    input logic [3:0]  p_status,
    input logic        p_perr_n,
    input logic [31:0] s_ad,
    input logic [3:0]  s_cbe,
    input logic        s_par,
    input logic        s_irdy,
    input logic        s_trdy,
    input logic        s_tgt_rd,
    input logic        s_resp_en,
    input logic        s_dpe_mask,
    input logic [3:0]  s_clr,
    input logic [3:0]  s_status,
    input logic        s_perr_n,
    input logic        up_flush,
    input logic        up_valid,
    input logic        dn_flush,
    input logic        dn_valid
);
    a_r1_p_perr_cause: assert property (@(posedge clk) disable iff (rst)
        !p_perr_n |-> ($past(p_tgt_rd && p_irdy && p_trdy, 3) &&
                       ($past(^{p_ad, p_cbe}, 3) != $past(p_par, 2))));

    a_r1_s_perr_cause: assert property (@(posedge clk) disable iff (rst)
        !s_perr_n |-> ($past(s_tgt_rd && s_irdy && s_trdy, 3) &&
                       ($past(^{s_ad, s_cbe}, 3) != $past(s_par, 2))));

    a_r2_p_perr_enable: assert property (@(posedge clk) disable iff (rst)
        !p_perr_n |-> $past(p_resp_en));

    a_r2_s_perr_enable: assert property (@(posedge clk) disable iff (rst)
        !s_perr_n |-> $past(s_resp_en));

    a_r3_s_dpd_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(s_status[0]) |-> $past(s_resp_en));

    a_r4_p_dpe_with_perr: assert property (@(posedge clk) disable iff (rst)
        !p_perr_n |-> p_status[1]);

    a_r5_p_mpe_mask: assert property (@(posedge clk) disable iff (rst)
        $rose(p_status[2]) |-> !$past(p_mpe_mask));

    a_r6_s_dpe_mask: assert property (@(posedge clk) disable iff (rst)
        $rose(s_status[3]) |-> !$past(s_dpe_mask));

    a_r7_p_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(p_status[1]) |-> $past(p_clr[1]));

    a_r7_s_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(s_status[1]) |-> $past(s_clr[1]));

    a_r9_up_flush_empties: assert property (@(posedge clk) disable iff (rst)
        up_flush |=> !up_valid);

    a_r9_dn_flush_empties: assert property (@(posedge clk) disable iff (rst)
        dn_flush |=> !dn_valid);
endmodule

bind prp_top prp_checker u_prp_checker (.*);

// File: tb/prp_top_tb.sv
module prp_top_tb;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic [31:0] in_ad   [2];
    logic [3:0]  in_cbe  [2];
    logic        in_par  [2];
    logic        in_irdy [2];
    logic        in_trdy [2];
    logic        in_tgt  [2];
    logic        in_resp [2];
    logic        in_mm   [2];
    logic        in_dm   [2];
    logic [3:0]  in_clr  [2];
    logic        in_pop  [2];
    logic        in_fl   [2];
    logic        bad_now [2];
    logic [35:0] pw      [2];

    logic [3:0]  o_stat [2];
    logic        o_perr [2];
    logic        o_val  [2];
    logic [31:0] o_ad   [2];
    logic [3:0]  o_cbe  [2];
    logic        o_par  [2];

    prp_top #(.DRC_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .p_ad(in_ad[0]), .p_cbe(in_cbe[0]), .p_par(in_par[0]),
        .p_irdy(in_irdy[0]), .p_trdy(in_trdy[0]), .p_tgt_rd(in_tgt[0]),
        .p_resp_en(in_resp[0]), .p_mpe_mask(in_mm[0]), .p_dpe_mask(in_dm[0]),
        .p_clr(in_clr[0]), .p_status(o_stat[0]), .p_perr_n(o_perr[0]),
        .s_ad(in_ad[1]), .s_cbe(in_cbe[1]), .s_par(in_par[1]),
        .s_irdy(in_irdy[1]), .s_trdy(in_trdy[1]), .s_tgt_rd(in_tgt[1]),
        .s_resp_en(in_resp[1]), .s_mpe_mask(in_mm[1]), .s_dpe_mask(in_dm[1]),
        .s_clr(in_clr[1]), .s_status(o_stat[1]), .s_perr_n(o_perr[1]),
        .up_pop(in_pop[0]), .up_flush(in_fl[0]), .up_valid(o_val[0]),
        .up_ad(o_ad[0]), .up_cbe(o_cbe[0]), .up_par(o_par[0]),
        .dn_pop(in_pop[1]), .dn_flush(in_fl[1]), .dn_valid(o_val[1]),
        .dn_ad(o_ad[1]), .dn_cbe(o_cbe[1]), .dn_par(o_par[1])
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model, one per side (index 0 primary / upstream, 1 secondary / downstream)
    logic        m_v1   [2];
    logic [35:0] m_w1   [2];
    logic        m_err  [2];
    logic        m_perr [2];
    logic [3:0]  m_st   [2];
    logic [36:0] q_up[$];
    logic [36:0] q_dn[$];

    function automatic logic par_bad(input logic [35:0] w, input logic p);
        return (^w) != p;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input int i);
        logic [3:0]  setv;
        logic        e_new;
        logic        push;
        logic [36:0] ent;
        int          sz;
        setv = {m_err[i] && !in_dm[i], m_err[i] && !in_mm[i], m_err[i], m_err[i] && in_resp[i]};
        m_st[i]   = (m_st[i] & ~in_clr[i]) | setv;
        m_perr[i] = m_err[i] && in_resp[i];
        e_new = m_v1[i] && par_bad(m_w1[i], in_par[i]);
        push  = m_v1[i];
        ent   = {m_w1[i], in_par[i]};
        sz = (i == 0) ? q_up.size() : q_dn.size();
        if (in_fl[i]) begin
            if (i == 0) q_up.delete(); else q_dn.delete();
        end else begin
            if (in_pop[i] && sz > 0) begin
                if (i == 0) void'(q_up.pop_front()); else void'(q_dn.pop_front());
            end
            if (push && sz < DEPTH) begin
                if (i == 0) q_up.push_back(ent); else q_dn.push_back(ent);
            end
        end
        m_err[i] = e_new;
        m_v1[i]  = in_tgt[i] && in_irdy[i] && in_trdy[i];
        m_w1[i]  = {in_ad[i], in_cbe[i]};
    endtask

    task automatic compare();
        logic [36:0] hd;
        int          sz;
        for (int i = 0; i < 2; i++) begin
            // R1 R2 R10 R11: parity error output of this side
            chk(i == 0 ? "R1/R2/R10/R11 p_perr_n" : "R1/R2/R10/R11 s_perr_n",
                64'(o_perr[i]), 64'(!m_perr[i]));
            chk("R3 status[0]", 64'(o_stat[i][0]), 64'(m_st[i][0]));
            chk("R4 status[1]", 64'(o_stat[i][1]), 64'(m_st[i][1]));
            chk("R5 status[2]", 64'(o_stat[i][2]), 64'(m_st[i][2]));
            chk("R6/R7 status[3]", 64'(o_stat[i][3]), 64'(m_st[i][3]));
            sz = (i == 0) ? q_up.size() : q_dn.size();
            chk("R9/R12 buffer valid", 64'(o_val[i]), 64'(sz > 0));
            if (sz > 0) begin
                hd = (i == 0) ? q_up[0] : q_dn[0];
                chk("R8 buffer head", 64'({o_ad[i], o_cbe[i], o_par[i]}), 64'(hd));
            end
        end
    endtask

    // one clock: drive (caller already set fields), edge, model, check at negedge
    task automatic step();
        for (int i = 0; i < 2; i++) in_par[i] = (^pw[i]) ^ bad_now[i];
        @(posedge clk);
        if (!rst) begin
            model_edge(0);
            model_edge(1);
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) pw[i] = {in_ad[i], in_cbe[i]};
        if (!rst) compare();
        for (int i = 0; i < 2; i++) begin
            in_clr[i]  = '0;
            in_pop[i]  = 1'b0;
            in_fl[i]   = 1'b0;
            bad_now[i] = 1'b0;
            in_tgt[i]  = 1'b0;
        end
    endtask

    task automatic phase(input int i, input logic [31:0] a, input logic [3:0] c);
        in_tgt[i] = 1'b1; in_irdy[i] = 1'b1; in_trdy[i] = 1'b1;
        in_ad[i] = a; in_cbe[i] = c;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0123));
        for (int i = 0; i < 2; i++) begin
            in_ad[i] = '0; in_cbe[i] = '0; in_par[i] = 1'b0;
            in_irdy[i] = 1'b0; in_trdy[i] = 1'b0; in_tgt[i] = 1'b0;
            in_resp[i] = 1'b1; in_mm[i] = 1'b0; in_dm[i] = 1'b0;
            in_clr[i] = '0; in_pop[i] = 1'b0; in_fl[i] = 1'b0;
            bad_now[i] = 1'b0; pw[i] = '0;
            m_v1[i] = 1'b0; m_w1[i] = '0; m_err[i] = 1'b0; m_perr[i] = 1'b0; m_st[i] = '0;
        end
        rst = 1'b1;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        // reset state (R1 R8): perr idle, status zero, buffers empty
        for (int i = 0; i < 2; i++) begin
            chk("R1 reset perr_n", 64'(o_perr[i]), 64'd1);
            chk("R7 reset status", 64'(o_stat[i]), 64'd0);
            chk("R8 reset valid", 64'(o_val[i]), 64'd0);
        end

        // R1 R11: back-to-back bad phases on secondary (downstream read)
        phase(1, 32'hDEAD_BEEF, 4'h0); step();
        phase(1, 32'h0000_0001, 4'hF); bad_now[1] = 1'b1; step();
        bad_now[1] = 1'b1; step();
        step(); step();
        // R10: primary side bad phase, secondary must stay quiet
        phase(0, 32'h1234_5678, 4'h3); step();
        bad_now[0] = 1'b1; step(); step(); step();
        // R2 R3: response disabled, error still lands in R4 bit
        in_clr[1] = 4'hF; step();
        in_resp[1] = 1'b0; in_mm[1] = 1'b1; in_dm[1] = 1'b1;
        phase(1, 32'hA5A5_A5A5, 4'h5); step();
        bad_now[1] = 1'b1; step(); step(); step();
        in_resp[1] = 1'b1; in_mm[1] = 1'b0; in_dm[1] = 1'b0;
        // R7: clear lands on the same edge as a new set
        phase(1, 32'h0F0F_0F0F, 4'h1); step();
        bad_now[1] = 1'b1; step();
        in_clr[1] = 4'hF; step();
        step();
        // R9: flush on the edge the bad word is written
        phase(1, 32'h7777_0000, 4'h2); step();
        bad_now[1] = 1'b1; in_fl[1] = 1'b1; step(); step(); step();
        // R12: fill past DEPTH without pops, then drain with pops on empty
        for (int k = 0; k < DEPTH + 3; k++) begin
            phase(0, 32'(k * 32'h0101_0101), 4'(k)); step();
        end
        for (int k = 0; k < DEPTH + 3; k++) begin
            in_pop[0] = 1'b1; step();
        end

        // constrained random traffic on both sides
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < 2; i++) begin
                in_tgt[i]  = ($urandom % 2) == 0;
                in_irdy[i] = ($urandom % 4) != 0;
                in_trdy[i] = ($urandom % 4) != 0;
                in_ad[i]   = $urandom;
                in_cbe[i]  = 4'($urandom);
                bad_now[i] = ($urandom % 4) == 0;
                in_pop[i]  = ($urandom % 2) == 0;
                in_fl[i]   = ($urandom % 24) == 0;
                in_clr[i]  = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
                if (($urandom % 32) == 0) in_resp[i] = ~in_resp[i];
                if (($urandom % 32) == 0) in_mm[i]   = ~in_mm[i];
                if (($urandom % 32) == 0) in_dm[i]   = ~in_dm[i];
            end
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule